// File: doc/BRIEF.md
# Sync Frequency and Polarity Monitor

This block measures the horizontal and vertical sync signals of a display input. It counts rising edges of the horizontal sync over a programmable gate window and times the vertical sync period in units of a fixed prescaled tick, which is 8 µs at the default setting. It also works out whether each input is active-low or active-high and drives a copy of each sync that is always active-high, or always active-low when the output-polarity select is set. Downstream mode-detection logic reads the latched counts. A mute interrupt tells it that the horizontal rate has moved by more than a programmable tolerance between two consecutive gates.

Both sync inputs are first passed through a two-stage synchronizer. Their rising edges drive four state machines. `sm_hfreq` runs `H_START → H_GATE`, stays in `H_GATE` until the gate ends (`gate_done`), then goes `H_GATE → H_CMP → H_GATE`. It latches the count on entry to `H_CMP` and compares it there. `sm_vperiod` runs `V_WAIT → V_RUN` on the first edge, stays in `V_RUN` on each later edge, and goes `V_RUN → V_SAT` when the tick count reaches full scale, returning `V_SAT → V_RUN` on the next edge. Each channel's `sm_polarity` goes `P_IDLE → P_TRACK` on the first edge and then judges polarity at every later edge. With the default parameters the gate lengths are 8.192, 16.384 and 32.768 ms, the horizontal count is 12 bits and the vertical count is 14 bits.

Top module: `sync_monitor`

## Requirements
- R1: After reset `hcount`, `vperiod`, `hovf`, `vovf`, `mute_irq`, `hpol_neg` and `vpol_neg` are all zero.
- R2: `hcount` holds the number of rising edges of the synchronized horizontal input within the last complete gate. The gate lasts GATE_TICKS ticks when `gate_sel` is 2'b00, twice that for 2'b01, and four times that for 2'b10 or 2'b11. A tick is TICK_DIV clocks.
- R3: If a gate holds more than 2^HCNT_W-1 edges, `hcount` saturates at all ones and `hovf` is set. `hovf` then stays set until a cycle with `hovf_clr` high and no new overflow.
- R4: At each rising edge of the synchronized vertical input after the first, `vperiod` latches the number of ticks since the previous rising edge.
- R5: When 2^VCNT_W-1 ticks pass without a vertical edge, `vperiod` is loaded with all ones and `vovf` is set. A period shorter than full scale never sets `vovf`.
- R6: `vovf` stays set until a cycle with `vovf_clr` high and no new saturation.
- R7: `hpol_neg` / `vpol_neg` become 1 when, over the last complete period, the input was high for strictly more cycles than low. A period with equal high and low time reports 0.
- R8: `hsync_out` equals the synchronized horizontal input (two clocks of latency), inverted when `hpol_neg` is 1 and inverted again when `hout_neg` is 1; `vsync_out` behaves the same with `vpol_neg` and `vout_neg`.
- R9: When a newly latched `hcount` differs from the previous one by more than `tol`, `mute_irq` is set. A difference equal to or less than `tol` leaves it unchanged.
- R10: The first count latched after reset is not compared, so it never raises `mute_irq`.
- R11: `mute_irq` stays set until a cycle with `mute_clr` high and no new mute event.
- R12: `hcount` changes only at the end of a gate, which falls on a tick. `vperiod` changes only on a vertical edge or a tick. A polarity status changes only on a rising edge of its input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync_in | input | 1 | Debounced horizontal sync level |
| vsync_in | input | 1 | Debounced vertical sync level |
| gate_sel | input | 2 | Gate length select (00: 1x, 01: 2x, 1x: 4x GATE_TICKS) |
| tol | input | TOL_W | Allowed change in horizontal count between gates |
| hout_neg | input | 1 | Drive horizontal output active-low |
| vout_neg | input | 1 | Drive vertical output active-low |
| hovf_clr | input | 1 | Clear pulse for `hovf` |
| vovf_clr | input | 1 | Clear pulse for `vovf` |
| mute_clr | input | 1 | Clear pulse for `mute_irq` |
| hcount | output | HCNT_W | Latched horizontal edge count |
| hovf | output | 1 | Horizontal count overflow flag |
| vperiod | output | VCNT_W | Latched vertical period in ticks |
| vovf | output | 1 | Vertical period saturation flag |
| hpol_neg | output | 1 | Horizontal input is active-low |
| vpol_neg | output | 1 | Vertical input is active-low |
| mute_irq | output | 1 | Horizontal rate change interrupt |
| hsync_out | output | 1 | Polarity-normalized horizontal sync |
| vsync_out | output | 1 | Polarity-normalized vertical sync |

## Verification
The assertions check on every cycle that the three flags are sticky until cleared and that a rising overflow flag arrives together with a full-scale count. They also check that a mute event follows a real change in the latched count, and that latches and polarity bits move only on ticks or input edges. The actual values need the bench's scenarios. Only those can show that edge counts match each gate length, that tick counts match the vertical period, how equal duty is judged, where the mute tolerance boundary lies, that the first gate after reset is exempt, and how the outputs respond to the polarity selects.

// File: rtl/sync_mon_pkg.sv
package sync_mon_pkg;

    typedef enum logic [1:0] {
        H_START = 2'd0,
        H_GATE  = 2'd1,
        H_CMP   = 2'd2
    } hstate_e;

    typedef enum logic [1:0] {
        V_WAIT = 2'd0,
        V_RUN  = 2'd1,
        V_SAT  = 2'd2
    } vstate_e;

    typedef enum logic {
        P_IDLE  = 1'b0,
        P_TRACK = 1'b1
    } pstate_e;

    localparam int NUM_CH = 2;
    localparam int CH_H   = 0;
    localparam int CH_V   = 1;

endpackage

// File: rtl/sm_tick_gen.sv
module sm_tick_gen #(
    parameter int DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/sm_hfreq.sv
module sm_hfreq
    import sync_mon_pkg::*;
#(
    parameter int HCNT_W     = 12,
    parameter int GATE_TICKS = 1024,
    parameter int TOL_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              pulse_in,
    input  logic [1:0]        gate_sel,
    input  logic [TOL_W-1:0]  tol,
    input  logic              ovf_clr,
    input  logic              mute_clr,
    output logic [HCNT_W-1:0] hcount,
    output logic              hovf,
    output logic              mute
);
    localparam int GW = $clog2(GATE_TICKS * 4 + 1);
    localparam logic [HCNT_W-1:0] HMAX = {HCNT_W{1'b1}};

    hstate_e state, nxt;

    logic [GW-1:0]     gcnt;
    logic [GW-1:0]     gate_len;
    logic [HCNT_W-1:0] cnt;
    logic [HCNT_W-1:0] cnt_inc;
    logic [HCNT_W-1:0] prev;
    logic [HCNT_W-1:0] diff;
    logic              cnt_ovf;
    logic              ovf_hit;
    logic              have_prev;
    logic              gate_done;
    logic              hovf_set;
    logic              mute_set;

    always_comb begin
        unique case (gate_sel)
            2'b00:   gate_len = GW'(GATE_TICKS);
            2'b01:   gate_len = GW'(GATE_TICKS * 2);
            default: gate_len = GW'(GATE_TICKS * 4);
        endcase
    end

    assign gate_done = (state == H_GATE) && tick && (gcnt >= gate_len - GW'(1));
    assign ovf_hit   = pulse_in && (cnt == HMAX);
    assign cnt_inc   = (pulse_in && (cnt != HMAX)) ? cnt + HCNT_W'(1) : cnt;
    assign diff      = (hcount >= prev) ? (hcount - prev) : (prev - hcount);
    assign hovf_set  = gate_done && (cnt_ovf || ovf_hit);
    assign mute_set  = (state == H_CMP) && have_prev && (diff > HCNT_W'(tol));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= H_START;
        end else begin
            state <= nxt;
        end
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            H_START: nxt = H_GATE;
            H_GATE:  nxt = gate_done ? H_CMP : H_GATE;
            H_CMP:   nxt = H_GATE;
            default: nxt = H_START;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gcnt      <= '0;
            cnt       <= '0;
            cnt_ovf   <= 1'b0;
            hcount    <= '0;
            prev      <= '0;
            have_prev <= 1'b0;
            hovf      <= 1'b0;
            mute      <= 1'b0;
        end else begin
            unique case (state)
                H_START: begin
                    gcnt    <= '0;
                    cnt     <= '0;
                    cnt_ovf <= 1'b0;
                end
                H_GATE: begin
                    if (gate_done) begin
                        hcount  <= cnt_inc;
                        cnt     <= '0;
                        cnt_ovf <= 1'b0;
                        gcnt    <= '0;
                    end else begin
                        cnt     <= cnt_inc;
                        cnt_ovf <= cnt_ovf | ovf_hit;
                        if (tick) begin
                            gcnt <= gcnt + GW'(1);
                        end
                    end
                end
                H_CMP: begin
                    cnt       <= cnt_inc;
                    cnt_ovf   <= cnt_ovf | ovf_hit;
                    if (tick) begin
                        gcnt <= gcnt + GW'(1);
                    end
                    prev      <= hcount;
                    have_prev <= 1'b1;
                end
                default: begin
                    gcnt <= '0;
                    cnt  <= '0;
                end
            endcase
            hovf <= hovf_set | (hovf & ~ovf_clr);
            mute <= mute_set | (mute & ~mute_clr);
        end
    end
endmodule

// File: rtl/sm_vperiod.sv
module sm_vperiod
    import sync_mon_pkg::*;
#(
    parameter int VCNT_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              pulse_in,
    input  logic              ovf_clr,
    output logic [VCNT_W-1:0] vperiod,
    output logic              vovf
);
    localparam logic [VCNT_W-1:0] VMAX  = {VCNT_W{1'b1}};
    localparam logic [VCNT_W-1:0] VLAST = VMAX - VCNT_W'(1);

    vstate_e state, nxt;

    logic [VCNT_W-1:0] cnt;
    logic              sat_hit;

    assign sat_hit = (state == V_RUN) && !pulse_in && tick && (cnt == VLAST);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= V_WAIT;
        end else begin
            state <= nxt;
        end
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            V_WAIT:  nxt = pulse_in ? V_RUN : V_WAIT;
            V_RUN:   nxt = sat_hit ? V_SAT : V_RUN;
            V_SAT:   nxt = pulse_in ? V_RUN : V_SAT;
            default: nxt = V_WAIT;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            vperiod <= '0;
            vovf    <= 1'b0;
        end else begin
            unique case (state)
                V_WAIT: begin
                    if (pulse_in) begin
                        cnt <= '0;
                    end
                end
                V_RUN: begin
                    if (pulse_in) begin
                        vperiod <= cnt + VCNT_W'(tick);
                        cnt     <= '0;
                    end else if (sat_hit) begin
                        vperiod <= VMAX;
                        cnt     <= '0;
                    end else if (tick) begin
                        cnt <= cnt + VCNT_W'(1);
                    end
                end
                V_SAT: begin
                    if (pulse_in) begin
                        cnt <= '0;
                    end
                end
                default: cnt <= '0;
            endcase
            vovf <= sat_hit | (vovf & ~ovf_clr);
        end
    end
endmodule

// File: rtl/sm_polarity.sv
module sm_polarity
    import sync_mon_pkg::*;
#(
    parameter int POL_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic pulse_in,
    output logic neg
);
    localparam logic [POL_W-1:0] PMAX = {POL_W{1'b1}};

    pstate_e state, nxt;

    logic [POL_W-1:0] hi_cnt;
    logic [POL_W-1:0] lo_cnt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= P_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            P_IDLE:  nxt = pulse_in ? P_TRACK : P_IDLE;
            P_TRACK: nxt = P_TRACK;
            default: nxt = P_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= '0;
            lo_cnt <= '0;
            neg    <= 1'b0;
        end else if (pulse_in) begin
            if (state == P_TRACK) begin
                neg <= (hi_cnt > lo_cnt);
            end
            hi_cnt <= POL_W'(1);
            lo_cnt <= '0;
        end else if (level) begin
            if (hi_cnt != PMAX) begin
                hi_cnt <= hi_cnt + POL_W'(1);
            end
        end else begin
            if (lo_cnt != PMAX) begin
                lo_cnt <= lo_cnt + POL_W'(1);
            end
        end
    end
endmodule

// File: rtl/sync_monitor.sv
module sync_monitor
    import sync_mon_pkg::*;
#(
    parameter int TICK_DIV    = 64,
    parameter int GATE_TICKS  = 1024,
    parameter int HCNT_W      = 12,
    parameter int VCNT_W      = 14,
    parameter int TOL_W       = 4,
    parameter int POL_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsync_in,
    input  logic              vsync_in,
    input  logic [1:0]        gate_sel,
    input  logic [TOL_W-1:0]  tol,
    input  logic              hout_neg,
    input  logic              vout_neg,
    input  logic              hovf_clr,
    input  logic              vovf_clr,
    input  logic              mute_clr,
    output logic [HCNT_W-1:0] hcount,
    output logic              hovf,
    output logic [VCNT_W-1:0] vperiod,
    output logic              vovf,
    output logic              hpol_neg,
    output logic              vpol_neg,
    output logic              mute_irq,
    output logic              hsync_out,
    output logic              vsync_out
);
    logic [NUM_CH-1:0] raw_in;
    logic [NUM_CH-1:0] lvl;
    logic [NUM_CH-1:0] edge_v;
    logic [NUM_CH-1:0] pol_neg;
    logic              tick;
    logic              h_edge;
    logic              v_edge;

    assign raw_in[CH_H] = hsync_in;
    assign raw_in[CH_V] = vsync_in;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        logic [SYNC_STAGES-1:0] sq;
        logic                   lvl_d;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sq    <= '0;
                lvl_d <= 1'b0;
            end else begin
                sq    <= {sq[SYNC_STAGES-2:0], raw_in[g]};
                lvl_d <= sq[SYNC_STAGES-1];
            end
        end

        assign lvl[g]    = sq[SYNC_STAGES-1];
        assign edge_v[g] = sq[SYNC_STAGES-1] & ~lvl_d;

        sm_polarity #(.POL_W(POL_W)) u_pol (
            .clk      (clk),
            .rst_n    (rst_n),
            .level    (lvl[g]),
            .pulse_in (edge_v[g]),
            .neg      (pol_neg[g])
        );
    end

    assign h_edge = edge_v[CH_H];
    assign v_edge = edge_v[CH_V];

    sm_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    sm_hfreq #(
        .HCNT_W     (HCNT_W),
        .GATE_TICKS (GATE_TICKS),
        .TOL_W      (TOL_W)
    ) u_hfreq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .pulse_in (h_edge),
        .gate_sel (gate_sel),
        .tol      (tol),
        .ovf_clr  (hovf_clr),
        .mute_clr (mute_clr),
        .hcount   (hcount),
        .hovf     (hovf),
        .mute     (mute_irq)
    );

    sm_vperiod #(.VCNT_W(VCNT_W)) u_vper (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .pulse_in (v_edge),
        .ovf_clr  (vovf_clr),
        .vperiod  (vperiod),
        .vovf     (vovf)
    );

    assign hpol_neg  = pol_neg[CH_H];
    assign vpol_neg  = pol_neg[CH_V];
    assign hsync_out = lvl[CH_H] ^ pol_neg[CH_H] ^ hout_neg;
    assign vsync_out = lvl[CH_V] ^ pol_neg[CH_V] ^ vout_neg;
endmodule

// File: rtl/sync_monitor_sva.sv
module sync_monitor_sva #(
    parameter int HCNT_W = 12,
    parameter int VCNT_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              h_edge,
    input logic              v_edge,
    input logic [HCNT_W-1:0] hcount,
    input logic              hovf,
    input logic              hovf_clr,
    input logic [VCNT_W-1:0] vperiod,
    input logic              vovf,
    input logic              vovf_clr,
    input logic              mute_irq,
    input logic              mute_clr,
    input logic              hpol_neg,
    input logic              vpol_neg
);
    a_r3_ovf_at_full_scale: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hovf) |-> (hcount == {HCNT_W{1'b1}}));

    a_r3_hovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (hovf && !hovf_clr) |=> hovf);

    a_r5_vovf_at_full_scale: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vovf) |-> (vperiod == {VCNT_W{1'b1}}));

    a_r6_vovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (vovf && !vovf_clr) |=> vovf);

    a_r11_mute_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (mute_irq && !mute_clr) |=> mute_irq);

    a_r9_mute_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mute_irq) |-> ($past(hcount) != $past(hcount, 2)));

    a_r12_hcount_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(hcount) |-> $past(tick));

    a_r12_vperiod_on_event: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vperiod) |-> $past(v_edge || tick));

    a_r7_hpol_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(hpol_neg) |-> $past(h_edge));

    a_r7_vpol_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vpol_neg) |-> $past(v_edge));
endmodule

bind sync_monitor sync_monitor_sva #(
    .HCNT_W (HCNT_W),
    .VCNT_W (VCNT_W)
) u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .h_edge   (h_edge),
    .v_edge   (v_edge),
    .hcount   (hcount),
    .hovf     (hovf),
    .hovf_clr (hovf_clr),
    .vperiod  (vperiod),
    .vovf     (vovf),
    .vovf_clr (vovf_clr),
    .mute_irq (mute_irq),
    .mute_clr (mute_clr),
    .hpol_neg (hpol_neg),
    .vpol_neg (vpol_neg)
);

// File: tb/sync_monitor_test.sv
`timescale 1ns/1ps
module sync_monitor_test;
    localparam int TICK_DIV   = 4;
    localparam int GATE_TICKS = 8;
    localparam int HCNT_W     = 6;
    localparam int VCNT_W     = 6;
    localparam int TOL_W      = 4;
    localparam int POL_W      = 10;
    localparam int SETTLE     = 1300;

    typedef struct packed {
        int hp;   int hh;   int sel;
        int vp;   int vh;
        int eh;   int ehneg; int ehovf;
        int ev;   int evneg; int evovf;
    } vec_t;

    // gate = 32/64/128 clocks, tick = 4 clocks, counters saturate at 63
    localparam vec_t VECS [6] = '{
        '{8,  2,  0, 40,  4,  4,  0, 0, 10, 0, 0},
        '{4,  3,  1, 100, 90, 16, 1, 0, 25, 1, 0},
        '{16, 12, 2, 200, 20, 8,  1, 0, 50, 0, 0},
        '{2,  1,  2, 60,  50, 63, 0, 1, 15, 1, 0},
        '{8,  2,  3, 400, 8,  16, 0, 0, 63, 0, 1},
        '{32, 4,  1, 248, 8,  2,  0, 0, 62, 0, 0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hsync_in = 1'b0;
    logic vsync_in = 1'b0;
    logic [1:0] gate_sel = 2'd0;
    logic [TOL_W-1:0] tol = '0;
    logic hout_neg = 1'b0;
    logic vout_neg = 1'b0;
    logic hovf_clr = 1'b0;
    logic vovf_clr = 1'b0;
    logic mute_clr = 1'b0;
    logic [HCNT_W-1:0] hcount;
    logic hovf;
    logic [VCNT_W-1:0] vperiod;
    logic vovf;
    logic hpol_neg;
    logic vpol_neg;
    logic mute_irq;
    logic hsync_out;
    logic vsync_out;

    int h_period = 0;
    int h_high = 0;
    logic h_idle = 1'b0;
    int v_period = 0;
    int v_high = 0;
    logic v_idle = 1'b0;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sync_monitor #(
        .TICK_DIV   (TICK_DIV),
        .GATE_TICKS (GATE_TICKS),
        .HCNT_W     (HCNT_W),
        .VCNT_W     (VCNT_W),
        .TOL_W      (TOL_W),
        .POL_W      (POL_W),
        .SYNC_STAGES(2)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .hsync_in  (hsync_in),
        .vsync_in  (vsync_in),
        .gate_sel  (gate_sel),
        .tol       (tol),
        .hout_neg  (hout_neg),
        .vout_neg  (vout_neg),
        .hovf_clr  (hovf_clr),
        .vovf_clr  (vovf_clr),
        .mute_clr  (mute_clr),
        .hcount    (hcount),
        .hovf      (hovf),
        .vperiod   (vperiod),
        .vovf      (vovf),
        .hpol_neg  (hpol_neg),
        .vpol_neg  (vpol_neg),
        .mute_irq  (mute_irq),
        .hsync_out (hsync_out),
        .vsync_out (vsync_out)
    );

    // horizontal waveform source
    initial begin
        forever begin
            if (h_period == 0) begin
                hsync_in = h_idle;
                @(negedge clk);
            end else begin
                hsync_in = 1'b1;
                repeat (h_high) @(negedge clk);
                hsync_in = 1'b0;
                repeat (h_period - h_high) @(negedge clk);
            end
        end
    end

    // vertical waveform source
    initial begin
        forever begin
            if (v_period == 0) begin
                vsync_in = v_idle;
                @(negedge clk);
            end else begin
                vsync_in = 1'b1;
                repeat (v_high) @(negedge clk);
                vsync_in = 1'b0;
                repeat (v_period - v_high) @(negedge clk);
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_ovf_clear();
        @(negedge clk);
        hovf_clr = 1'b1;
        vovf_clr = 1'b1;
        @(negedge clk);
        hovf_clr = 1'b0;
        vovf_clr = 1'b0;
    endtask

    task automatic pulse_mute_clear();
        @(negedge clk);
        mute_clr = 1'b1;
        @(negedge clk);
        mute_clr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // stimulus running through reset; first gate must not be compared
        gate_sel = 2'd2;
        tol      = 4'd1;
        h_period = 8;  h_high = 2;
        v_period = 40; v_high = 4;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        check("R1 hcount", int'(hcount), 0);
        check("R1 vperiod", int'(vperiod), 0);
        check("R1 hovf", int'(hovf), 0);
        check("R1 vovf", int'(vovf), 0);
        check("R1 mute_irq", int'(mute_irq), 0);
        check("R1 hpol_neg", int'(hpol_neg), 0);
        check("R1 vpol_neg", int'(vpol_neg), 0);

        repeat (450) @(negedge clk);
        check("R2 hcount after reset", int'(hcount), 16);
        check("R10 first gate not compared", int'(mute_irq), 0);
        check("R4 vperiod after reset", int'(vperiod), 10);

        // table walk
        tol = 4'd15;
        for (int i = 0; i < 6; i++) begin
            h_period = VECS[i].hp;
            h_high   = VECS[i].hh;
            gate_sel = 2'(VECS[i].sel);
            v_period = VECS[i].vp;
            v_high   = VECS[i].vh;
            repeat (SETTLE) @(negedge clk);
            pulse_ovf_clear();
            repeat (SETTLE) @(negedge clk);
            check($sformatf("R2 hcount vec%0d", i), int'(hcount), VECS[i].eh);
            check($sformatf("R7 hpol_neg vec%0d", i), int'(hpol_neg), VECS[i].ehneg);
            check($sformatf("R3 hovf vec%0d", i), int'(hovf), VECS[i].ehovf);
            check($sformatf("R4 vperiod vec%0d", i), int'(vperiod), VECS[i].ev);
            check($sformatf("R7 vpol_neg vec%0d", i), int'(vpol_neg), VECS[i].evneg);
            check($sformatf("R5 R6 vovf vec%0d", i), int'(vovf), VECS[i].evovf);
        end

        // mute tolerance: 16 -> 4 with tol 5 mutes, 4 -> 16 with tol 12 does not
        tol = 4'd5;
        gate_sel = 2'd2;
        h_period = 8; h_high = 2;
        repeat (700) @(negedge clk);
        pulse_mute_clear();
        repeat (300) @(negedge clk);
        check("R9 steady rate no mute", int'(mute_irq), 0);
        h_period = 32; h_high = 4;
        repeat (700) @(negedge clk);
        check("R9 jump above tol mutes", int'(mute_irq), 1);
        check("R11 mute held", int'(mute_irq), 1);
        pulse_mute_clear();
        repeat (300) @(negedge clk);
        check("R11 mute cleared", int'(mute_irq), 0);
        tol = 4'd12;
        h_period = 8; h_high = 2;
        repeat (700) @(negedge clk);
        check("R9 jump equal to tol no mute", int'(mute_irq), 0);
        check("R2 hcount after jump", int'(hcount), 16);

        // output polarity with an active-low horizontal input
        h_period = 16; h_high = 12;
        repeat (700) @(negedge clk);
        check("R7 hpol_neg active-low", int'(hpol_neg), 1);
        h_idle = 1'b1; h_period = 0;
        repeat (20) @(negedge clk);
        hout_neg = 1'b0;
        @(negedge clk);
        check("R8 idle high, out active-high", int'(hsync_out), 0);
        hout_neg = 1'b1;
        @(negedge clk);
        check("R8 idle high, out active-low", int'(hsync_out), 1);
        h_idle = 1'b0;
        repeat (6) @(negedge clk);
        check("R8 pulse low, out active-low", int'(hsync_out), 0);
        hout_neg = 1'b0;
        @(negedge clk);
        check("R8 pulse low, out active-high", int'(hsync_out), 1);
        check("R7 no edge keeps polarity", int'(hpol_neg), 1);

        // vertical output with active-high input (last table entry)
        vout_neg = 1'b1;
        v_idle = 1'b0; v_period = 0;
        repeat (10) @(negedge clk);
        check("R8 vsync idle low, out active-low", int'(vsync_out), 1);
        vout_neg = 1'b0;
        @(negedge clk);
        check("R8 vsync idle low, out active-high", int'(vsync_out), 0);

        // vertical input stopped: saturation, then clear
        repeat (600) @(negedge clk);
        check("R5 stopped vsync saturates", int'(vperiod), 63);
        check("R5 stopped vsync flag", int'(vovf), 1);
        pulse_ovf_clear();
        repeat (2) @(negedge clk);
        check("R6 vovf cleared", int'(vovf), 0);
        check("R5 vperiod holds full scale", int'(vperiod), 63);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule